// File: doc/BRIEF.md
# Descriptor ring pointer register bank

This block is the register-side bookkeeping for one circular queue of DMA descriptors in an Ethernet MAC. The same block serves each of the rings such a MAC uses: the receive ring software fills with free buffers, the receive ring hardware fills with finished frames, the transmit ring software fills with frames to send, and the transmit ring hardware fills with reclaimed descriptors. It holds the ring base address, the ring depth, and a producer and a consumer pointer. Both pointers are kept as byte offsets into the ring, where each descriptor occupies 32 bytes.

One pointer is owned by software and written through the register port. The other is owned by the DMA engine and advanced one descriptor per strobe on `hw_adv`. The parameter `SW_PRODUCES` picks which side owns which pointer. The engine's strobes only act while the bit chosen by `GATE_SEL` is set in the shared four-bit queue gate. That gate has bit 3 for receive output writes, bit 2 for receive input reads, bit 1 for transmit output writes and bit 0 for transmit input reads.

The block drives empty, full, the pending descriptor count and the byte address of the descriptor the engine should touch next. Base and depth can only be changed through a two-step unlock protocol.

Top module: `desc_ring_regs`

## Requirements
- R1: After reset the base reads 0, the depth register reads `MAX_DESC<<3`, both pointers read 0, the unlock register reads 0 and the ring reports empty.
- R2: Register select codes are 0 base, 1 depth, 2 producer pointer, 3 consumer pointer, 4 unlock, 5 status. A write to base takes effect only while unlock bit 2 is set, and a write to depth only while unlock bit 1 is set. Otherwise the write is ignored. The unlock register reads back bits 2 and 1 as written.
- R3: The depth register holds the descriptor count shifted left by 3. An unlocked depth write is ignored unless its low 3 bits are zero and the count lies in 2..MAX_DESC.
- R4: An accepted base or depth write returns both pointers to zero.
- R5: Pointers read as descriptor index shifted left by 5. A software write to its own pointer is ignored unless the value is a multiple of 32 and its index is below the ring count. Writes to the hardware-owned pointer are always ignored.
- R6: Each cycle with `hw_adv` high and the gate open moves the hardware-owned pointer by one descriptor, wrapping to zero on reaching the count.
- R7: While the selected gate bit is clear, `hw_adv` has no effect on the pointers or on the error flag.
- R8: The ring is empty when the pointers are equal and full when advancing the producer would make them equal. One slot is always left unused. Pending is the producer-minus-consumer distance modulo the count.
- R9: A gated strobe that would consume from an empty ring or produce into a full ring is dropped and sets a sticky error flag. Status reads as bit 0 empty, bit 1 full, bit 2 error, bits 15:8 pending. A status read clears the error flag, and a drop in the same cycle wins.
- R10: `desc_addr` equals the base plus the byte offset of the hardware-owned pointer.
- R11: With `SW_PRODUCES`=1, software owns the producer pointer and hardware consumes. With `SW_PRODUCES`=0, hardware produces and software owns the consumer pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears error on status read) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_sel`, combinational |
| queue_gate | input | 4 | Shared queue gate bits |
| hw_adv | input | 1 | Engine advance strobe for the hardware-owned pointer |
| desc_addr | output | ADDR_W | Byte address of the engine's current descriptor |
| ring_empty | output | 1 | Ring empty |
| ring_full | output | 1 | Ring full |
| ring_pending | output | CNT_W | Descriptors between consumer and producer |

## Verification
The bench builds two copies with `MAX_DESC`=8. The first uses `SW_PRODUCES`=1 and gate bit 0. The second uses `SW_PRODUCES`=0 and gate bit 3, so both ownership variants and two gate positions are exercised. Programming the first copy down to a count of 4 makes wrap-around, the full condition and the empty-ring drop reachable within a handful of strobes. The second copy at its full count of 8 reaches the full drop after seven strobes and then wraps its producer.

// File: rtl/drq_pkg.sv
package drq_pkg;

  typedef enum logic [2:0] {
    RS_BASE   = 3'd0,
    RS_DEPTH  = 3'd1,
    RS_PROD   = 3'd2,
    RS_CONS   = 3'd3,
    RS_UNLOCK = 3'd4,
    RS_STAT   = 3'd5
  } drq_sel_e;

  // next index around a ring of cnt entries
  function automatic logic [31:0] ring_next(input logic [31:0] idx, input logic [31:0] cnt);
    logic [31:0] n;
    n = idx + 32'd1;
    return (n >= cnt) ? 32'd0 : n;
  endfunction

  // entries between consumer and producer
  function automatic logic [31:0] ring_pending(input logic [31:0] prod, input logic [31:0] cons,
                                               input logic [31:0] cnt);
    return (prod >= cons) ? (prod - cons) : (cnt - cons + prod);
  endfunction

  // depth register value acceptable: count<<3, count in 2..max
  function automatic logic depth_ok(input logic [31:0] wdata, input logic [31:0] max_cnt);
    logic [31:0] c;
    c = wdata >> 3;
    return (wdata[2:0] == 3'd0) && (c >= 32'd2) && (c <= max_cnt);
  endfunction

  // pointer value acceptable: 32-byte aligned and inside ring
  function automatic logic ptr_ok(input logic [31:0] wdata, input logic [31:0] cnt);
    return (wdata[4:0] == 5'd0) && ((wdata >> 5) < cnt);
  endfunction

endpackage

// File: rtl/drq_cfg.sv
module drq_cfg #(
  parameter int ADDR_W   = 32,
  parameter int MAX_DESC = 64,
  parameter int CNT_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [31:0]       wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [1:0]        unlock_q,   // [1] base, [0] depth
  output logic              cfg_load
);
  import drq_pkg::*;

  logic wr_base, wr_depth;

  assign wr_base  = wr_en && (sel == 3'(RS_BASE)) && unlock_q[1];
  assign wr_depth = wr_en && (sel == 3'(RS_DEPTH)) && unlock_q[0]
                    && depth_ok(wdata, 32'(MAX_DESC));
  assign cfg_load = wr_base || wr_depth;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= CNT_W'(MAX_DESC);
      unlock_q <= '0;
    end else begin
      if (wr_base)  base_q <= wdata[ADDR_W-1:0];
      if (wr_depth) cnt_q  <= CNT_W'(wdata >> 3);
      if (wr_en && (sel == 3'(RS_UNLOCK))) unlock_q <= {wdata[2], wdata[1]};
    end
  end

  // R2: locked fields do not move
  a_r2_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_q[1] |=> $stable(base_q));
  a_r2_depth_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_q[0] |=> $stable(cnt_q));
  // R3: count stays in its legal range
  a_r3_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CNT_W'(2)) && (cnt_q <= CNT_W'(MAX_DESC)));

endmodule

// File: rtl/drq_ptr.sv
module drq_ptr #(
  parameter int IDX_W       = 6,
  parameter int CNT_W       = 7,
  parameter bit SW_PRODUCES = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cfg_load,
  input  logic             sw_wr,
  input  logic [2:0]       sw_sel,
  input  logic [31:0]      sw_wdata,
  input  logic             hw_req,
  input  logic             stat_rd,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] cons_idx,
  output logic [IDX_W-1:0] hw_ptr,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] pending,
  output logic             err_q,
  output logic             hw_step,
  output logic             hw_drop
);
  import drq_pkg::*;

  localparam bit       HW_PROD = !SW_PRODUCES;
  localparam drq_sel_e SW_REG  = HW_PROD ? RS_CONS : RS_PROD;

  logic [IDX_W-1:0] prod_nxt, cons_nxt, sw_idx;
  logic             sw_ptr_ok, hw_blocked;

  assign prod_nxt  = IDX_W'(ring_next(32'(prod_idx), 32'(cnt)));
  assign cons_nxt  = IDX_W'(ring_next(32'(cons_idx), 32'(cnt)));
  assign empty     = (prod_idx == cons_idx);
  assign full      = (prod_nxt == cons_idx);
  assign pending   = CNT_W'(ring_pending(32'(prod_idx), 32'(cons_idx), 32'(cnt)));
  assign sw_idx    = IDX_W'(sw_wdata >> 5);
  assign sw_ptr_ok = sw_wr && (sw_sel == 3'(SW_REG)) && ptr_ok(sw_wdata, 32'(cnt));

  assign hw_blocked = HW_PROD ? full : empty;
  assign hw_step    = hw_req && !hw_blocked;
  assign hw_drop    = hw_req && hw_blocked;

  generate
    if (HW_PROD) begin : g_hw_prod
      always_ff @(posedge clk) begin
        if (!rst_n || cfg_load) begin
          prod_idx <= '0;
          cons_idx <= '0;
        end else begin
          if (hw_step)   prod_idx <= prod_nxt;
          if (sw_ptr_ok) cons_idx <= sw_idx;
        end
      end
      assign hw_ptr = prod_idx;
    end else begin : g_sw_prod
      always_ff @(posedge clk) begin
        if (!rst_n || cfg_load) begin
          prod_idx <= '0;
          cons_idx <= '0;
        end else begin
          if (sw_ptr_ok) prod_idx <= sw_idx;
          if (hw_step)   cons_idx <= cons_nxt;
        end
      end
      assign hw_ptr = cons_idx;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (hw_drop) err_q <= 1'b1;
    else if (stat_rd) err_q <= 1'b0;
  end

  // R5: pointers remain inside the ring
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(prod_idx) < 32'(cnt)) && (32'(cons_idx) < 32'(cnt)));
  // R8: never empty and full at once
  a_r8_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  // R9: a dropped strobe leaves the error flag set
  a_r9_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hw_drop |=> err_q);
  // R6: an accepted strobe moves the engine pointer by one, wrapping
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_step && !cfg_load) |=>
      (hw_ptr == IDX_W'(ring_next(32'($past(hw_ptr)), 32'($past(cnt))))));
  // R4: configuration load zeroes both pointers
  a_r4_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (prod_idx == '0) && (cons_idx == '0));

endmodule

// File: rtl/drq_rdmux.sv
module drq_rdmux #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 7
) (
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [IDX_W-1:0]  prod_idx,
  input  logic [IDX_W-1:0]  cons_idx,
  input  logic [1:0]        unlock,
  input  logic              empty,
  input  logic              full,
  input  logic              err,
  input  logic [CNT_W-1:0]  pending,
  output logic [31:0]       rdata
);
  import drq_pkg::*;

  always_comb begin
    case (sel)
      3'(RS_BASE):   rdata = 32'(base);
      3'(RS_DEPTH):  rdata = 32'({cnt, 3'b000});
      3'(RS_PROD):   rdata = 32'({prod_idx, 5'b00000});
      3'(RS_CONS):   rdata = 32'({cons_idx, 5'b00000});
      3'(RS_UNLOCK): rdata = {29'd0, unlock, 1'b0};
      3'(RS_STAT):   rdata = {16'd0, 8'(pending), 5'd0, err, full, empty};
      default:       rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/desc_ring_regs.sv
module desc_ring_regs #(
  parameter int    MAX_DESC    = 64,
  parameter int    ADDR_W      = 32,
  parameter bit    SW_PRODUCES = 1'b1,
  parameter int    GATE_SEL    = 0,
  localparam int   IDX_W       = $clog2(MAX_DESC),
  localparam int   CNT_W       = $clog2(MAX_DESC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        queue_gate,
  input  logic              hw_adv,
  output logic [ADDR_W-1:0] desc_addr,
  output logic              ring_empty,
  output logic              ring_full,
  output logic [CNT_W-1:0]  ring_pending
);
  import drq_pkg::*;

  localparam logic [3:0] GATE_MASK = 4'(1 << GATE_SEL);

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        unlock_q;
  logic              cfg_load;
  logic [IDX_W-1:0]  prod_idx, cons_idx, hw_ptr;
  logic              gate_on, hw_req, stat_rd, err_q, hw_step, hw_drop;

  assign gate_on = |(queue_gate & GATE_MASK);
  assign hw_req  = hw_adv && gate_on;
  assign stat_rd = reg_rd && (reg_sel == 3'(RS_STAT));

  drq_cfg #(.ADDR_W(ADDR_W), .MAX_DESC(MAX_DESC), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .base_q(base_q), .cnt_q(cnt_q), .unlock_q(unlock_q), .cfg_load(cfg_load)
  );

  drq_ptr #(.IDX_W(IDX_W), .CNT_W(CNT_W), .SW_PRODUCES(SW_PRODUCES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cfg_load(cfg_load),
    .sw_wr(reg_wr), .sw_sel(reg_sel), .sw_wdata(reg_wdata),
    .hw_req(hw_req), .stat_rd(stat_rd),
    .prod_idx(prod_idx), .cons_idx(cons_idx), .hw_ptr(hw_ptr),
    .empty(ring_empty), .full(ring_full), .pending(ring_pending),
    .err_q(err_q), .hw_step(hw_step), .hw_drop(hw_drop)
  );

  drq_rdmux #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rd (
    .sel(reg_sel), .base(base_q), .cnt(cnt_q), .prod_idx(prod_idx),
    .cons_idx(cons_idx), .unlock(unlock_q), .empty(ring_empty), .full(ring_full),
    .err(err_q), .pending(ring_pending), .rdata(reg_rdata)
  );

  assign desc_addr = base_q + ADDR_W'({hw_ptr, 5'b00000});

  // R7: closed gate freezes the engine pointer and the error flag
  a_r7_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_on && !cfg_load) |=> $stable(hw_ptr));
  a_r7_gate_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> !$rose(err_q));
  // R9: step and drop are exclusive and only follow a strobe
  a_r9_step_or_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_step && hw_drop) && ((hw_step || hw_drop) == hw_req));

endmodule

// File: tb/desc_ring_regs_test.sv
`timescale 1ns/1ps
module desc_ring_regs_test;
  localparam int MD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        wr_a = 0, rd_a = 0, adv_a = 0;
  logic        wr_b = 0, rd_b = 0, adv_b = 0;
  logic [3:0]  gate_a = 4'b0001, gate_b = 4'b1000;
  logic [31:0] rdata_a, rdata_b, addr_a, addr_b;
  logic        empty_a, full_a, empty_b, full_b;
  logic [3:0]  pend_a, pend_b;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  desc_ring_regs #(.MAX_DESC(MD), .SW_PRODUCES(1'b1), .GATE_SEL(0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_rd(rd_a), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .queue_gate(gate_a), .hw_adv(adv_a),
    .desc_addr(addr_a), .ring_empty(empty_a), .ring_full(full_a), .ring_pending(pend_a));

  desc_ring_regs #(.MAX_DESC(MD), .SW_PRODUCES(1'b0), .GATE_SEL(3)) uut_rb (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_rd(rd_b), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .queue_gate(gate_b), .hw_adv(adv_b),
    .desc_addr(addr_b), .ring_empty(empty_b), .ring_full(full_b), .ring_pending(pend_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int t, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d;
    if (t == 0) wr_a = 1'b1; else wr_b = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input int t, input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    if (t == 0) rd_a = 1'b1; else rd_b = 1'b1;
    #1 v = (t == 0) ? rdata_a : rdata_b;
    @(negedge clk);
    rd_a = 1'b0; rd_b = 1'b0;
  endtask

  task automatic adv(input int t, input int n);
    @(negedge clk);
    if (t == 0) adv_a = 1'b1; else adv_b = 1'b1;
    repeat (n) @(negedge clk);
    adv_a = 1'b0; adv_b = 1'b0;
  endtask

  // status word: bit0 empty, bit1 full, bit2 error, bits15:8 pending
  function automatic logic [31:0] st(input int pend, input bit e, input bit f, input bit er);
    return (32'(pend) << 8) | {29'd0, er, f, e};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 3'd0, v); chk("R1 base after reset", v, 32'd0);
    rd(0, 3'd1, v); chk("R1 depth after reset", v, 32'(MD << 3));
    rd(0, 3'd2, v); chk("R1 producer after reset", v, 32'd0);
    rd(0, 3'd4, v); chk("R1 unlock after reset", v, 32'd0);
    rd(0, 3'd5, v); chk("R1 status after reset", v, st(0, 1, 0, 0));
    chk("R1 desc_addr after reset", addr_a, 32'd0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    wr(0, 3'd0, 32'h1000_0000);
    rd(0, 3'd0, v); chk("R2 locked base write ignored", v, 32'd0);
    wr(0, 3'd4, 32'h4);
    rd(0, 3'd4, v); chk("R2 unlock readback", v, 32'h4);
    wr(0, 3'd0, 32'h2000_0100);
    wr(0, 3'd4, 32'h0);
    wr(0, 3'd0, 32'h0000_0003);
    rd(0, 3'd0, v); chk("R2 base unlocked then relocked", v, 32'h2000_0100);
    wr(0, 3'd1, 32'd32);
    rd(0, 3'd1, v); chk("R2 locked depth write ignored", v, 32'(MD << 3));
    wr(0, 3'd4, 32'h2);
    wr(0, 3'd1, 32'd8);
    wr(0, 3'd1, 32'((MD + 1) << 3));
    wr(0, 3'd1, 32'd33);
    rd(0, 3'd1, v); chk("R3 bad depth values ignored", v, 32'(MD << 3));
    wr(0, 3'd1, 32'd32);
    wr(0, 3'd4, 32'h0);
    rd(0, 3'd1, v); chk("R3 depth count 4 accepted", v, 32'd32);
  endtask

  task automatic t_swptr();
    logic [31:0] v;
    wr(0, 3'd2, 32'h40);
    rd(0, 3'd2, v); chk("R5 producer write accepted", v, 32'h40);
    rd(0, 3'd5, v); chk("R8 pending two", v, st(2, 0, 0, 0));
    wr(0, 3'd2, 32'h44);
    wr(0, 3'd2, 32'h80);
    rd(0, 3'd2, v); chk("R5 misaligned and out-of-ring writes ignored", v, 32'h40);
    wr(0, 3'd3, 32'h20);
    rd(0, 3'd3, v); chk("R5 engine-owned pointer write ignored", v, 32'd0);
    chk("R10 desc_addr at consumer 0", addr_a, 32'h2000_0100);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    gate_a = 4'b1110;
    adv(0, 1);
    rd(0, 3'd3, v); chk("R7 closed gate leaves consumer", v, 32'd0);
    rd(0, 3'd5, v); chk("R7 closed gate no error", v, st(2, 0, 0, 0));
    gate_a = 4'b0001;
    adv(0, 1);
    rd(0, 3'd3, v); chk("R6 consumer steps", v, 32'h20);
    chk("R10 desc_addr follows consumer", addr_a, 32'h2000_0120);
  endtask

  task automatic t_full_drain();
    logic [31:0] v;
    wr(0, 3'd2, 32'h00);
    rd(0, 3'd5, v); chk("R8 full with one slot unused", v, st(3, 0, 1, 0));
    chk("R8 full port", {31'd0, full_a}, 32'd1);
    adv(0, 3);
    rd(0, 3'd3, v); chk("R6 consumer wraps to zero", v, 32'd0);
    adv(0, 1);
    rd(0, 3'd3, v); chk("R9 empty drop keeps consumer", v, 32'd0);
    rd(0, 3'd5, v); chk("R9 error set after drop", v, st(0, 1, 0, 1));
    rd(0, 3'd5, v); chk("R9 error cleared by read", v, st(0, 1, 0, 0));
  endtask

  task automatic t_reload();
    logic [31:0] v;
    wr(0, 3'd2, 32'h40);
    adv(0, 1);
    wr(0, 3'd4, 32'h4);
    wr(0, 3'd0, 32'h4000_0000);
    wr(0, 3'd4, 32'h0);
    rd(0, 3'd2, v); chk("R4 base load clears producer", v, 32'd0);
    rd(0, 3'd3, v); chk("R4 base load clears consumer", v, 32'd0);
    chk("R10 desc_addr new base", addr_a, 32'h4000_0000);
  endtask

  task automatic t_hwprod();
    logic [31:0] v;
    rd(1, 3'd5, v); chk("R11 hw-produce ring empty at reset", v, st(0, 1, 0, 0));
    gate_b = 4'b0111;
    adv(1, 1);
    rd(1, 3'd2, v); chk("R7 other gate bits do not open", v, 32'd0);
    gate_b = 4'b1000;
    adv(1, MD - 1);
    rd(1, 3'd5, v); chk("R11 hw produces to full", v, st(MD - 1, 0, 1, 0));
    chk("R10 desc_addr at producer", addr_b, 32'((MD - 1) * 32));
    adv(1, 1);
    rd(1, 3'd5, v); chk("R9 full drop sets error", v, st(MD - 1, 0, 1, 1));
    wr(1, 3'd2, 32'h20);
    rd(1, 3'd2, v); chk("R5 sw cannot write hw producer", v, 32'((MD - 1) * 32));
    wr(1, 3'd3, 32'((MD - 1) * 32));
    rd(1, 3'd5, v); chk("R11 sw consumer release empties", v, st(0, 1, 0, 0));
    adv(1, 1);
    rd(1, 3'd2, v); chk("R6 producer wraps to zero", v, 32'd0);
    rd(1, 3'd5, v); chk("R8 pending across wrap", v, st(1, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlock();
    t_swptr();
    t_gate();
    t_full_drain();
    t_reload();
    t_hwprod();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule